// File: doc/BRIEF.md
# Configurable External Interrupt Sense Unit

This block turns eight asynchronous external interrupt request pins into eight synchronous request lines. A 16-bit sense register has one two-bit field per pin. Software uses that field to pick, at run time, whether a pin requests service while it is held low, or on a falling edge, a rising edge or either edge. The register is split into a low byte and a high byte. Software reaches both bytes, and a write-only clear register, over a plain byte-wide register port with one write strobe and combinational read data.

Each pin passes through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one clock earlier. In the edge modes a detected edge sets a pending flag, and the flag stays set until software writes a 1 to that pin's bit in the clear register. In level mode the request follows the synchronised low level and nothing is latched. A priority controller downstream receives the request lines. The register port has no back-pressure, so every write strobe takes effect in the cycle it is presented.

Top module: `irq_sense_unit`

## Requirements
- R1: After reset both sense bytes read 0x00, every pin is in low-level mode, and all requests are 0 while the pins are high.
- R2: Address 0 reads and writes the low byte (bits 7:0) and address 1 the high byte (bits 15:8). Pin n uses bits 2n+1:2n, so pin 0 is bits 1:0 of address 0 and pin 4 is bits 1:0 of address 1.
- R3: Field 00 (low level): the request for a pin is 1 exactly while the pin, delayed by two clocks, is low. It is not latched.
- R4: Field 01 (falling): a high-to-low change on the pin sets the request on the third rising clock edge after the change. The request then holds through later pin activity. Rising edges are ignored.
- R5: Field 10 (rising): a low-to-high change sets the request with the same three-edge latency. Falling edges are ignored.
- R6: Field 11 (both): each change in either direction sets the request with the same latency.
- R7: A write to address 2 clears the pending request of every pin whose data bit n is 1, at that write's clock edge. Pins whose bit is 0 keep their state.
- R8: When an edge is detected in the same cycle as a clear write for that pin, the edge wins and the request stays set.
- R9: A write that changes a pin's field clears that pin's pending request. A write that leaves the field unchanged keeps it, including a write that changes other pins' fields in the same byte.
- R10: While the standby input is high at a clock edge, both sense bytes and all pending flags are cleared, exactly as after reset.
- R11: Reads of address 2 or 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Synchronous clear of configuration and pending state |
| irq_in | input | 8 | External request pins, asynchronous |
| reg_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 clear |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_req | output | 8 | Request lines, one per pin |

## Verification
Each of the four sense fields is driven with a falling change, a rising change and a long held level. This separates level following from edge latching, and separates the direction each edge mode accepts from the one it rejects. Clear writes are tried with a selected bit, with that bit deselected and in the exact cycle an edge lands, which tells "clear wins" apart from "set wins". Byte writes that do and do not alter a pin's field show the mode-change clear. A long random mix of pin toggles, field writes, clears and standby pulses is compared each cycle against a bench model of the rules.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int BYTE_W = 8;
  localparam int FIELD_W = 2;

endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/irqs_cfg_regs.sv
module irqs_cfg_regs
  import irqs_pkg::*;
#(
  parameter int PINS = 8,
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 standby,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [2*PINS-1:0]    cfg,
  output logic [PINS-1:0]      mode_chg,
  output logic [PINS-1:0]      clr_hit,
  output logic [BYTE_W-1:0]    rdata
);

  localparam int CFG_W = FIELD_W * PINS;
  localparam int NBYTES = CFG_W / BYTE_W;
  localparam int PINS_PER_BYTE = BYTE_W / FIELD_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (standby) begin
      cfg <= '0;
    end else if (wr) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (addr == ADDR_W'(b)) cfg[b*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (addr == ADDR_W'(b)) rdata = cfg[b*BYTE_W +: BYTE_W];
    end
  end

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    localparam int CFG_BYTE = n / PINS_PER_BYTE;
    localparam int FIELD_LSB = (FIELD_W * n) % BYTE_W;
    localparam int CLR_ADDR = NBYTES + n / BYTE_W;
    localparam int CLR_BIT = n % BYTE_W;

    assign mode_chg[n] = wr && !standby && (addr == ADDR_W'(CFG_BYTE)) &&
                         (wdata[FIELD_LSB +: FIELD_W] != cfg[FIELD_W*n +: FIELD_W]);
    assign clr_hit[n]  = wr && (addr == ADDR_W'(CLR_ADDR)) && wdata[CLR_BIT];
  end

endmodule

// File: rtl/irqs_detect.sv
module irqs_detect
  import irqs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   standby,
  input  logic   sync_in,
  input  sense_e mode,
  input  logic   mode_chg,
  input  logic   clr_hit,
  output logic   req
);

  logic prev_q;
  logic pend_q;
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_in;
  end

  always_comb begin
    unique case (mode)
      SENSE_FALL: hit = prev_q & ~sync_in;
      SENSE_RISE: hit = ~prev_q & sync_in;
      SENSE_BOTH: hit = prev_q ^ sync_in;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (standby || mode_chg || (mode == SENSE_LOW)) begin
      pend_q <= 1'b0;
    end else if (hit) begin
      pend_q <= 1'b1;
    end else if (clr_hit) begin
      pend_q <= 1'b0;
    end
  end

  assign req = (mode == SENSE_LOW) ? ~sync_in : pend_q;

endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
  import irqs_pkg::*;
#(
  parameter int PINS = 8,
  parameter int ADDR_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic [PINS-1:0]   irq_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [PINS-1:0]   irq_req
);

  logic [2*PINS-1:0] cfg_q;
  logic [PINS-1:0]   mode_chg;
  logic [PINS-1:0]   clr_hit;
  logic [PINS-1:0]   pin_sync;

  irqs_sync #(
    .W(PINS),
    .STAGES(SYNC_STAGES),
    .RST_VAL({PINS{1'b1}})
  ) u_sync (
    .clk(clk),
    .rst_n(rst_n),
    .d(irq_in),
    .q(pin_sync)
  );

  irqs_cfg_regs #(
    .PINS(PINS),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk),
    .rst_n(rst_n),
    .standby(standby),
    .wr(reg_wr),
    .addr(reg_addr),
    .wdata(reg_wdata),
    .cfg(cfg_q),
    .mode_chg(mode_chg),
    .clr_hit(clr_hit),
    .rdata(reg_rdata)
  );

  for (genvar n = 0; n < PINS; n++) begin : g_det
    irqs_detect u_det (
      .clk(clk),
      .rst_n(rst_n),
      .standby(standby),
      .sync_in(pin_sync[n]),
      .mode(sense_e'(cfg_q[2*n +: 2])),
      .mode_chg(mode_chg[n]),
      .clr_hit(clr_hit[n]),
      .req(irq_req[n])
    );
  end

endmodule

// File: rtl/irqs_checker.sv
module irqs_checker #(
  parameter int PINS = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic [PINS-1:0]   irq_in,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic [PINS-1:0]   irq_req,
  input logic [2*PINS-1:0] cfg
);

  localparam int NBYTES = (2 * PINS) / 8;

  logic [PINS-1:0] d1, d2, d3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= '1;
      d2 <= '1;
      d3 <= '1;
    end else begin
      d1 <= irq_in;
      d2 <= d1;
      d3 <= d2;
    end
  end

  // R10: standby returns configuration to zero, requests follow level mode
  a_r10_standby_clear: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (cfg == '0) && (irq_req == ~d2));

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    // R2: a byte write lands in its own byte of the sense register
    a_r2_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !standby && reg_addr == ADDR_W'(b))
      |=> cfg[8*b +: 8] == $past(reg_wdata));
  end

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    localparam int CFG_BYTE = n / 4;
    localparam int CLR_ADDR = NBYTES + n / 8;

    // R3: level mode follows the twice-delayed pin low level
    a_r3_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[2*n +: 2] == 2'b00) |-> (irq_req[n] == ~d2[n]));

    // R4: a latched edge request survives without clear, mode write or standby
    a_r4_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg[2*n +: 2] != 2'b00) && irq_req[n] && !standby &&
       !(reg_wr && reg_addr == ADDR_W'(CFG_BYTE)) &&
       !(reg_wr && reg_addr == ADDR_W'(CLR_ADDR) && reg_wdata[n % 8]))
      |=> irq_req[n]);

    // R7: a clear with no edge in the same cycle drops the request
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg[2*n +: 2] != 2'b00) && !standby && (d2[n] == d3[n]) &&
       reg_wr && reg_addr == ADDR_W'(CLR_ADDR) && reg_wdata[n % 8])
      |=> !irq_req[n]);
  end

endmodule

bind irq_sense_unit irqs_checker #(
  .PINS(PINS),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .standby(standby),
  .irq_in(irq_in),
  .reg_addr(reg_addr),
  .reg_wr(reg_wr),
  .reg_wdata(reg_wdata),
  .irq_req(irq_req),
  .cfg(cfg_q)
);

// File: tb/test_irq_sense_unit.sv
module test_irq_sense_unit;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic [7:0] irq_in = 8'hFF;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] irq_req;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 0;

  irq_sense_unit i_irq_sense_unit (
    .clk(clk), .rst_n(rst_n), .standby(standby), .irq_in(irq_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model of the requirements
  logic [7:0]  m_s1, m_s2, m_prev, m_pend, np;
  logic [15:0] m_cfg, nc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 8'hFF; m_s2 <= 8'hFF; m_prev <= 8'hFF;
      m_cfg <= 16'h0; m_pend <= 8'h0;
    end else begin
      nc = m_cfg;
      if (reg_wr && reg_addr == 2'd0) nc[7:0] = reg_wdata;
      if (reg_wr && reg_addr == 2'd1) nc[15:8] = reg_wdata;
      for (int n = 0; n < 8; n++) begin
        logic [1:0] f;
        logic edge_seen;
        f = m_cfg[2*n +: 2];
        edge_seen = (f == 2'b01) ? (m_prev[n] & ~m_s2[n]) :
                    (f == 2'b10) ? (~m_prev[n] & m_s2[n]) :
                    (f == 2'b11) ? (m_prev[n] ^ m_s2[n]) : 1'b0;
        if (standby || f == 2'b00 || nc[2*n +: 2] != f) np[n] = 1'b0;
        else if (edge_seen) np[n] = 1'b1;
        else if (reg_wr && reg_addr == 2'd2 && reg_wdata[n]) np[n] = 1'b0;
        else np[n] = m_pend[n];
      end
      if (standby) nc = 16'h0;
      m_s1 <= irq_in; m_s2 <= m_s1; m_prev <= m_s2;
      m_cfg <= nc; m_pend <= np;
    end
  end

  function automatic logic [7:0] exp_req(input logic [15:0] c, input logic [7:0] s,
                                         input logic [7:0] p);
    logic [7:0] r;
    for (int n = 0; n < 8; n++) r[n] = (c[2*n +: 2] == 2'b00) ? ~s[n] : p[n];
    return r;
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [15:0] c, input logic [1:0] a);
    return (a == 2'd0) ? c[7:0] : (a == 2'd1) ? c[15:8] : 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    check("R1 req", irq_req, 8'h00);
    rd_check("R1 low byte", 2'd0, 8'h00);
    rd_check("R1 high byte", 2'd1, 8'h00);

    // R4 falling mode on pin 0
    wr(2'd0, 8'h01);
    step(3);
    irq_in[0] = 1'b0; step(2);
    check("R4 before third edge", irq_req, 8'h00);
    step(1);
    check("R4 set", irq_req, 8'h01);
    irq_in[0] = 1'b1; step(4);
    check("R4 held", irq_req, 8'h01);
    wr(2'd2, 8'hFE);
    check("R7 zero bit keeps", irq_req, 8'h01);
    wr(2'd2, 8'h01);
    check("R7 clear", irq_req, 8'h00);
    irq_in[0] = 1'b0; step(4); wr(2'd2, 8'h01);
    irq_in[0] = 1'b1; step(4);
    check("R4 rising ignored", irq_req, 8'h00);

    // R5 rising mode
    wr(2'd0, 8'h02);
    irq_in[0] = 1'b0; step(4);
    check("R5 falling ignored", irq_req, 8'h00);
    irq_in[0] = 1'b1; step(3);
    check("R5 set", irq_req, 8'h01);
    wr(2'd2, 8'h01);

    // R6 both edges
    wr(2'd0, 8'h03);
    irq_in[0] = 1'b0; step(3);
    check("R6 falling", irq_req, 8'h01);
    wr(2'd2, 8'h01);
    check("R6 cleared", irq_req, 8'h00);
    irq_in[0] = 1'b1; step(3);
    check("R6 rising", irq_req, 8'h01);
    wr(2'd2, 8'h01);

    // R8 edge and clear in the same cycle
    irq_in[0] = 1'b0; step(2);
    wr(2'd2, 8'h01);
    check("R8 set wins", irq_req, 8'h01);

    // R9 mode-change clear
    wr(2'd0, 8'h03);
    check("R9 same field keeps", irq_req, 8'h01);
    wr(2'd0, 8'h0B);
    check("R9 other pin changed", irq_req, 8'h01);
    wr(2'd0, 8'h09);
    check("R9 own field changed", irq_req, 8'h00);
    irq_in[0] = 1'b1; step(3);

    // R3 level mode on pin 5
    wr(2'd0, 8'h00);
    irq_in[5] = 1'b0; step(1);
    check("R3 one edge", irq_req, 8'h00);
    step(1);
    check("R3 follows low", irq_req, 8'h20);
    step(3);
    check("R3 stays while low", irq_req, 8'h20);
    irq_in[5] = 1'b1; step(2);
    check("R3 not latched", irq_req, 8'h00);

    // R2 byte access and R11
    wr(2'd1, 8'hA5);
    wr(2'd0, 8'h3C);
    rd_check("R2 high byte", 2'd1, 8'hA5);
    rd_check("R2 low byte", 2'd0, 8'h3C);
    rd_check("R11 addr 2", 2'd2, 8'h00);
    rd_check("R11 addr 3", 2'd3, 8'h00);

    // R2 pin 4 is bits 1:0 of the high byte (01 falling)
    step(1);
    irq_in[4] = 1'b0; step(3);
    check("R2 pin 4 falling", irq_req, 8'h10);

    // R10 standby
    standby = 1'b1; step(1); standby = 1'b0;
    rd_check("R10 low byte", 2'd0, 8'h00);
    rd_check("R10 high byte", 2'd1, 8'h00);
    check("R10 level mode after", irq_req, 8'h10);
    irq_in[4] = 1'b1; step(2);
    check("R10 pending gone", irq_req, 8'h00);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      check("R6 model req", irq_req, exp_req(m_cfg, m_s2, m_pend));
      irq_in = irq_in ^ (($urandom % 4 == 0) ? 8'($urandom) : 8'h00);
      reg_addr = 2'($urandom);
      reg_wdata = 8'($urandom);
      reg_wr = ($urandom % 6 == 0);
      standby = ($urandom % 200 == 0);
      #1;
      check("R2 model rdata", reg_rdata, exp_rdata(m_cfg, reg_addr));
    end
    @(negedge clk);
    reg_wr = 1'b0; standby = 1'b0;
    step(1);
    check("R9 model final", irq_req, exp_req(m_cfg, m_s2, m_pend));

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule